// File: doc/BRIEF.md
# Host Bus Byte FIFO Bridge

This block joins an 8-bit host I/O bus to on-chip logic through two decoded port addresses. Bytes the host writes to the data port are queued in an inbound FIFO that the on-chip logic drains. Bytes the on-chip logic queues in an outbound FIFO are returned to the host when it reads the data port. The second port, the control port, has two meanings. A host write to it is a broadcast soft reset: both queues are emptied and a reset pulse goes out to the modules behind the bridge. A host read of it returns a status byte with the empty and full flags of both queues.

The bus is modelled as single-cycle synchronous strobes. A read or write is accepted on the clock edge where its strobe is high. An address match counts only while the address-enable line is low. Read data and its output enable are combinational from the current state, so they are valid in the same cycle as the read strobe. Every change of FIFO state takes effect at the edge.

Top module: `hostbus_fifo_if`

## Requirements
- R1: A bus cycle is decoded only while `bus_aen` is low. With `bus_aen` high, writes change nothing, reads leave `bus_rdata_oe` low, and control writes start no pulse.
- R2: A data-port write pushes `bus_wdata` into the inbound FIFO. The on-chip side sees the bytes in arrival order on `in_rd_data`, and each `in_rd_en` pulse removes the head byte.
- R3: A data-port write while the inbound FIFO holds DEPTH bytes is dropped. The stored bytes stay unchanged.
- R4: A data-port read returns the head of the outbound FIFO in the same cycle and removes it at the clock edge. Bytes come out in the order they were queued.
- R5: A data-port read while the outbound FIFO is empty returns 0x00 and leaves FIFO state unchanged.
- R6: A control-port read returns a status byte: bit 0 inbound empty, bit 1 inbound full, bit 2 outbound empty, bit 3 outbound full, all other bits zero.
- R7: After a control-port write, `soft_rst_out` is high for exactly RST_CYCLES (default 4) cycles, starting in the cycle after the write. A new control write restarts the count.
- R8: A control-port write empties both FIFOs at its edge. While `soft_rst_out` is high, both FIFOs stay empty and pushes from either side are dropped.
- R9: `bus_rdata_oe` is high only during a decoded read of either port. At all other times `bus_rdata` is 0x00.
- R10: After `rst_n` is deasserted, both FIFOs are empty, `soft_rst_out` is low and `bus_rdata_oe` is low.
- R11: `out_wr_en` while the outbound FIFO is full is dropped. `in_rd_en` while the inbound FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_aen | input | 1 | Address enable; high blocks decoding |
| bus_wr | input | 1 | Host write strobe, one cycle per transfer |
| bus_rd | input | 1 | Host read strobe, one cycle per transfer |
| bus_wdata | input | DATA_W | Host write byte |
| bus_rdata | output | DATA_W | Host read byte |
| bus_rdata_oe | output | 1 | Drive enable for the host data lines |
| soft_rst_out | output | 1 | Reset pulse to attached modules |
| in_rd_en | input | 1 | On-chip pop of the inbound FIFO |
| in_rd_data | output | DATA_W | Inbound FIFO head byte |
| in_empty | output | 1 | Inbound FIFO empty |
| in_full | output | 1 | Inbound FIFO full |
| out_wr_en | input | 1 | On-chip push into the outbound FIFO |
| out_wr_data | input | DATA_W | Byte pushed into the outbound FIFO |
| out_empty | output | 1 | Outbound FIFO empty |
| out_full | output | 1 | Outbound FIFO full |

## Verification
Read data and the output enable are due in the same cycle as the read strobe. FIFO flags, the inbound head byte and queue contents change one edge after the strobe that causes them. The soft reset output rises one edge after the control write and falls RST_CYCLES edges later. The bench drives every input at the falling edge and compares all outputs 1 ns later against a queue-based model, before the rising edge that would act on those inputs. The model then advances at that rising edge using the same held inputs, so each expected value is compared in exactly the cycle it is due.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    localparam int ST_IN_EMPTY  = 0;
    localparam int ST_IN_FULL   = 1;
    localparam int ST_OUT_EMPTY = 2;
    localparam int ST_OUT_FULL  = 3;
    localparam int ST_USED_BITS = 4;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic ctrl_wr;
        logic ctrl_rd;
    } hbf_hit_t;
endpackage

// File: rtl/hbf_fifo.sv
module hbf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CAP);
        do_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CAP);
endmodule

// File: rtl/hbf_decode.sv
module hbf_decode
    import hbf_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 10'h300,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h301
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_aen,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output hbf_hit_t          hit
);
    logic sel_data, sel_ctrl;

    always_comb begin
        sel_data    = !bus_aen && (bus_addr == DATA_ADDR);
        sel_ctrl    = !bus_aen && (bus_addr == CTRL_ADDR);
        hit.data_wr = sel_data && bus_wr;
        hit.data_rd = sel_data && bus_rd;
        hit.ctrl_wr = sel_ctrl && bus_wr;
        hit.ctrl_rd = sel_ctrl && bus_rd;
    end
endmodule

// File: rtl/hbf_softrst.sv
module hbf_softrst #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rst_st_t;

    rst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trigger)              st_d.cnt = LOAD;
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/hostbus_fifo_if.sv
module hostbus_fifo_if
    import hbf_pkg::*;
#(
    parameter int              ADDR_W     = 10,
    parameter int              DATA_W     = 8,
    parameter int              DEPTH      = 4,
    parameter int              RST_CYCLES = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 10'h300,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 10'h301
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_aen,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              soft_rst_out,
    input  logic              in_rd_en,
    output logic [DATA_W-1:0] in_rd_data,
    output logic              in_empty,
    output logic              in_full,
    input  logic              out_wr_en,
    input  logic [DATA_W-1:0] out_wr_data,
    output logic              out_empty,
    output logic              out_full
);
    hbf_hit_t          hit;
    logic              flush;
    logic [DATA_W-1:0] out_head;
    logic [DATA_W-1:0] status;

    hbf_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_ADDR(DATA_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .bus_addr(bus_addr),
        .bus_aen (bus_aen),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .hit     (hit)
    );

    hbf_softrst #(.CYCLES(RST_CYCLES)) u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .trigger(hit.ctrl_wr),
        .active (soft_rst_out)
    );

    assign flush = hit.ctrl_wr || soft_rst_out;

    hbf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_infifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (hit.data_wr),
        .push_data(bus_wdata),
        .pop      (in_rd_en),
        .head     (in_rd_data),
        .empty    (in_empty),
        .full     (in_full)
    );

    hbf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_outfifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (out_wr_en),
        .push_data(out_wr_data),
        .pop      (hit.data_rd),
        .head     (out_head),
        .empty    (out_empty),
        .full     (out_full)
    );

    always_comb begin
        status               = '0;
        status[ST_IN_EMPTY]  = in_empty;
        status[ST_IN_FULL]   = in_full;
        status[ST_OUT_EMPTY] = out_empty;
        status[ST_OUT_FULL]  = out_full;
    end

    always_comb begin
        bus_rdata    = '0;
        bus_rdata_oe = hit.data_rd || hit.ctrl_rd;
        if (hit.data_rd) bus_rdata = out_empty ? '0 : out_head;
        else if (hit.ctrl_rd) bus_rdata = status;
    end
endmodule

// File: rtl/hbf_chk.sv
module hbf_chk #(
    parameter int              ADDR_W     = 10,
    parameter int              DATA_W     = 8,
    parameter int              RST_CYCLES = 4,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 10'h300,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 10'h301
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_aen,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rdata_oe,
    input logic              soft_rst_out,
    input logic              in_rd_en,
    input logic              in_empty,
    input logic              in_full,
    input logic              out_empty,
    input logic              out_full
);
    logic ctrl_wr_seen, data_rd_seen;
    int   run_q;

    assign ctrl_wr_seen = bus_wr && !bus_aen && (bus_addr == CTRL_ADDR);
    assign data_rd_seen = bus_rd && !bus_aen && (bus_addr == DATA_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr_seen || !soft_rst_out) run_q <= 0;
        else run_q <= run_q + 1;
    end

    a_r1_aen_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aen |-> !bus_rdata_oe);

    a_r9_no_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (!bus_rdata_oe && bus_rdata == '0));

    a_r7_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_seen |=> soft_rst_out);

    a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_out |-> (run_q < RST_CYCLES));

    a_r8_flushed_while_pulsing: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_out |-> (in_empty && out_empty));

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_seen && out_empty) |-> (bus_rdata == '0));

    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && !in_rd_en && !ctrl_wr_seen) |=> in_full);

    a_r11_out_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full && !data_rd_seen && !ctrl_wr_seen) |=> out_full);
endmodule

bind hostbus_fifo_if hbf_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RST_CYCLES(RST_CYCLES),
    .DATA_ADDR (DATA_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_aen     (bus_aen),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .bus_rdata_oe(bus_rdata_oe),
    .soft_rst_out(soft_rst_out),
    .in_rd_en    (in_rd_en),
    .in_empty    (in_empty),
    .in_full     (in_full),
    .out_empty   (out_empty),
    .out_full    (out_full)
);

// File: tb/sim_hostbus_fifo_if.sv
module sim_hostbus_fifo_if;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 4;
    localparam int RSTC   = 4;
    localparam logic [9:0] DA = 10'h300;
    localparam logic [9:0] CA = 10'h301;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] bus_addr;
    logic       bus_aen, bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       bus_rdata_oe, soft_rst_out;
    logic       in_rd_en, in_empty, in_full;
    logic [7:0] in_rd_data;
    logic       out_wr_en, out_empty, out_full;
    logic [7:0] out_wr_data;

    always #10 clk = ~clk;

    hostbus_fifo_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .soft_rst_out(soft_rst_out), .in_rd_en(in_rd_en),
        .in_rd_data(in_rd_data), .in_empty(in_empty), .in_full(in_full),
        .out_wr_en(out_wr_en), .out_wr_data(out_wr_data),
        .out_empty(out_empty), .out_full(out_full)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] inq[$], outq[$];
    int srst = 0;
    logic [7:0] last_rd;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_status();
        logic [7:0] s = 8'h00;
        s[0] = (inq.size() == 0);
        s[1] = (inq.size() == DEPTH);
        s[2] = (outq.size() == 0);
        s[3] = (outq.size() == DEPTH);
        return s;
    endfunction

    task automatic compare();
        bit dw, dr, cw, cr;
        logic [7:0] er;
        string tag;
        dr = bus_rd && !bus_aen && bus_addr == DA;
        cr = bus_rd && !bus_aen && bus_addr == CA;
        er = 8'h00; tag = "R9";
        if (dr) begin
            er = (outq.size() == 0) ? 8'h00 : outq[0];
            tag = (outq.size() == 0) ? "R5" : "R4";
        end else if (cr) begin
            er = model_status(); tag = "R6";
        end
        chk(bus_rdata == er, tag, "bus_rdata", bus_rdata, er);
        chk(bus_rdata_oe == (dr || cr), "R9", "bus_rdata_oe", bus_rdata_oe, dr || cr);
        chk(soft_rst_out == (srst != 0), "R7", "soft_rst_out", soft_rst_out, srst != 0);
        chk(in_empty == (inq.size() == 0), "R2", "in_empty", in_empty, inq.size() == 0);
        chk(in_full == (inq.size() == DEPTH), "R3", "in_full", in_full, inq.size() == DEPTH);
        chk(out_empty == (outq.size() == 0), "R4", "out_empty", out_empty, outq.size() == 0);
        chk(out_full == (outq.size() == DEPTH), "R11", "out_full", out_full, outq.size() == DEPTH);
        if (inq.size() != 0)
            chk(in_rd_data == inq[0], "R2", "in_rd_data", in_rd_data, inq[0]);
    endtask

    task automatic advance();
        bit dw, dr, cw;
        int ni, no;
        dw = bus_wr && !bus_aen && bus_addr == DA;
        cw = bus_wr && !bus_aen && bus_addr == CA;
        dr = bus_rd && !bus_aen && bus_addr == DA;
        ni = inq.size(); no = outq.size();
        if (cw) begin
            inq.delete(); outq.delete(); srst = RSTC;
        end else if (srst != 0) begin
            inq.delete(); outq.delete(); srst--;
        end else begin
            if (in_rd_en && ni > 0) void'(inq.pop_front());
            if (dw && ni < DEPTH) inq.push_back(bus_wdata);
            if (dr && no > 0) void'(outq.pop_front());
            if (out_wr_en && no < DEPTH) outq.push_back(out_wr_data);
        end
    endtask

    task automatic cycle();
        #1;
        compare();
        last_rd = bus_rdata;
        @(posedge clk);
        if (rst_n) advance();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_aen = 0; in_rd_en = 0; out_wr_en = 0;
    endtask

    task automatic host_wr(logic [9:0] a, logic [7:0] d, logic aen);
        bus_addr = a; bus_wdata = d; bus_aen = aen; bus_wr = 1; cycle();
    endtask

    task automatic host_rd(logic [9:0] a, logic aen);
        bus_addr = a; bus_aen = aen; bus_rd = 1; cycle();
    endtask

    task automatic core_push(logic [7:0] d);
        out_wr_en = 1; out_wr_data = d; cycle();
    endtask

    task automatic core_pop();
        in_rd_en = 1; cycle();
    endtask

    initial begin
        #4_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hi;
        rst_n = 0; bus_addr = '0; bus_aen = 0; bus_wr = 0; bus_rd = 0;
        bus_wdata = '0; in_rd_en = 0; out_wr_en = 0; out_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk(in_empty && out_empty, "R10", "fifos empty", {in_empty, out_empty}, 3);
        chk(!soft_rst_out && !bus_rdata_oe, "R10", "pulse/oe", {soft_rst_out, bus_rdata_oe}, 0);
        @(negedge clk);

        // R2 ordered delivery
        host_wr(DA, 8'hA1, 0); host_wr(DA, 8'hA2, 0); host_wr(DA, 8'hA3, 0);
        #1 chk(in_rd_data == 8'hA1, "R2", "first head", in_rd_data, 8'hA1);
        core_pop();
        #1 chk(in_rd_data == 8'hA2, "R2", "second head", in_rd_data, 8'hA2);
        core_pop(); core_pop();
        #1 chk(in_empty, "R2", "drained", in_empty, 1);

        // R1 address enable blocks decoding
        host_wr(DA, 8'h55, 1);
        #1 chk(in_empty, "R1", "aen write ignored", in_empty, 1);
        bus_addr = DA; bus_aen = 1; bus_rd = 1; #1;
        chk(!bus_rdata_oe, "R1", "aen read oe", bus_rdata_oe, 0);
        cycle();
        host_wr(CA, 8'h00, 1);
        #1 chk(!soft_rst_out, "R1", "aen ctrl write", soft_rst_out, 0);

        // R3 overflow dropped, R6 status
        for (int i = 0; i < DEPTH + 1; i++) host_wr(DA, 8'hB0 + 8'(i), 0);
        #1 chk(in_full, "R3", "in_full", in_full, 1);
        host_rd(CA, 0);
        chk(last_rd == 8'h06, "R6", "status in full", last_rd, 8'h06);
        for (int i = 0; i < DEPTH; i++) begin
            #1 chk(in_rd_data == 8'hB0 + 8'(i), "R3", "kept byte", in_rd_data, 8'hB0 + i);
            core_pop();
        end
        #1 chk(in_empty, "R3", "extra byte dropped", in_empty, 1);

        // R11 pop on empty has no effect
        core_pop();
        host_wr(DA, 8'hC7, 0);
        #1 chk(in_rd_data == 8'hC7 && !in_empty, "R11", "after empty pop", in_rd_data, 8'hC7);
        core_pop();

        // R4 outbound order, R11 overflow, R5 empty read
        for (int i = 0; i < DEPTH + 1; i++) core_push(8'hD0 + 8'(i));
        host_rd(CA, 0);
        chk(last_rd == 8'h09, "R6", "status out full", last_rd, 8'h09);
        for (int i = 0; i < DEPTH; i++) begin
            host_rd(DA, 0);
            chk(last_rd == 8'hD0 + 8'(i), "R4", "outbound byte", last_rd, 8'hD0 + i);
        end
        host_rd(DA, 0);
        chk(last_rd == 8'h00, "R5", "empty read", last_rd, 0);
        chk(out_empty, "R11", "fifth byte dropped", out_empty, 1);
        core_push(8'hE1);
        host_rd(DA, 0);
        chk(last_rd == 8'hE1, "R5", "state kept after empty read", last_rd, 8'hE1);

        // R7 / R8 soft reset pulse and flush
        host_wr(DA, 8'h11, 0); host_wr(DA, 8'h12, 0); core_push(8'h21);
        host_wr(CA, 8'h00, 0);
        #1 chk(in_empty && out_empty, "R8", "flushed", {in_empty, out_empty}, 3);
        hi = 0;
        for (int i = 0; i < RSTC + 3; i++) begin
            #1 if (soft_rst_out) hi++;
            if (i == 1) begin bus_addr = DA; bus_wdata = 8'h99; bus_wr = 1; out_wr_en = 1; out_wr_data = 8'h98; end
            cycle();
        end
        chk(hi == RSTC, "R7", "pulse length", hi, RSTC);
        #1 chk(in_empty && out_empty, "R8", "pushes dropped", {in_empty, out_empty}, 3);

        // R7 retrigger restarts count
        host_wr(CA, 8'h00, 0); cycle(); host_wr(CA, 8'h00, 0);
        hi = 0;
        for (int i = 0; i < RSTC + 2; i++) begin
            #1 if (soft_rst_out) hi++;
            cycle();
        end
        chk(hi == RSTC, "R7", "retriggered length", hi, RSTC);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule